// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave side of the serial control port of a multichannel converter. A host selects it with an active-low chip select and moves bits over a serial clock, a data input and a data output. Each transaction opens with a one-byte command. The command names one register and says whether that register will be read or written. The controller then shifts the register in or out at the register's own width. The conversion logic sits outside the block and is reached through plain register ports: status bytes are loaded through a small write port, and the channel results arrive on a flat input bus.

The serial pins are synchronised into the system clock, and the serial clock edges are found by oversampling. The serial clock idles high. The host changes the data input before each rising edge, and the block samples it on that rising edge. The block updates its data output on each falling edge.

Two further features share the same pins. The first is a software reset: a long run of ones on the data input restores every register to its default value. The second is a continuous-read mode. In this mode the block streams one channel's status and result for as long as the host keeps the data input low.

Top module: `ser_reg_ctrl`

## Requirements
- R1: After rst_n is released, zs_cal reads 0x800000, mode_val and mode_ch read 0, sdo_en is 0, and status register n holds 0x20*n.
- R2: A command byte is bit 7 = 0, bit 6 = 1 for read and 0 for write, and bits 5:0 = register address. A byte with bit 7 set is discarded, and the next 8 bits form a fresh command byte.
- R3: A write to address 0x06 takes 24 data bits, most significant bit first, and the new value appears on zs_cal.
- R4: During a read, sdo_en is 1. The register's bits appear on sdo most significant bit first. Each bit is updated on a falling serial clock edge and is valid at the following rising edge.
- R5: Addresses 0x20+n are 8-bit read-only status registers. A cycle with stat_wr high loads stat_val into status register stat_sel.
- R6: Addresses 0x08+n read channel n's result from conv_data bits [24n+23:24n]. When mode bit 1 is 0, only the upper 16 bits are sent (16 bits). When mode bit 1 is 1, all 24 bits are sent.
- R7: The 8-bit mode register is written at any address 0x38+k. The write sets mode_val and sets mode_ch to k. A read at 0x38 returns the mode value, and reads at 0x39 to 0x3F return 0x00.
- R8: Writes to read-only or unmapped addresses have no effect. Reads of unmapped addresses return 8 zero bits.
- R9: While cs_n is high, sclk and sdi are ignored and sdo_en is 0. Raising cs_n abandons a partly shifted transaction.
- R10: 32 consecutive ones sampled on sdi with cs_n low restore every register to its R1 value. This holds even in the middle of a transaction, and the block then waits for a command byte.
- R11: A mode write with bit 2 set enters continuous read. While sdi is low, the block sends repeated frames of status byte mode_ch followed by result mode_ch, with the result width set by R6.
- R12: A 1 on sdi at the first bit of a stream frame clears mode bit 2, and that bit is discarded. The next 8 bits are a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data into the block |
| stat_wr | input | 1 | Load strobe for a status register |
| stat_sel | input | 3 | Status register selected by stat_wr |
| stat_val | input | 8 | Value loaded by stat_wr |
| conv_data | input | 192 | Channel results, channel n in bits [24n+23:24n] |
| sdo | output | 1 | Serial data out of the block |
| sdo_en | output | 1 | Output enable for sdo; 0 means high impedance |
| mode_val | output | 8 | Current mode register |
| mode_ch | output | 3 | Channel named by the last mode write |
| zs_cal | output | 24 | Zero-scale calibration register |

## Verification
The bench builds the block with its default values: eight channels, 24-bit results, two synchroniser stages and a 32-bit reset run. Eight channels make every mode alias from 0x38 to 0x3F a live address. This lets the bench confirm that the write address picks the channel and that only the base alias reads back. A 24-bit result width makes the 16-bit and 24-bit data reads, and 32-bit stream frames, differ in length. The 32-one threshold is longer than any register, so the bench can show a reset run that crosses a write, a stream exit and several discarded command bytes.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
    typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_STREAM} ser_st_e;

    localparam logic [5:0] A_ZSCAL = 6'h06;
    localparam logic [2:0] A_DATA_HI = 3'b001;
    localparam logic [2:0] A_STAT_HI = 3'b100;
    localparam logic [2:0] A_MODE_HI = 3'b111;
    localparam logic [5:0] A_MODE = 6'h38;

    localparam int MB_WIDE = 1;
    localparam int MB_CONT = 2;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= STAGES'({chain_q, d});
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ser_rdmux.sv
module ser_rdmux
    import ser_reg_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 24,
    parameter int FW  = 8 + DW
) (
    input  logic [5:0]               addr,
    input  logic [7:0]               mode,
    input  logic [DW-1:0]            zs,
    input  logic [NCH-1:0][7:0]      stat,
    input  logic [NCH-1:0][DW-1:0]   data,
    output logic [FW-1:0]            val,
    output logic [5:0]               len
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CHW-1:0] idx;
    logic           in_range;

    assign idx      = addr[CHW-1:0];
    assign in_range = int'(addr[2:0]) < NCH;

    always_comb begin
        val = '0;
        len = 6'd8;
        if (addr == A_ZSCAL) begin
            val[FW-1 -: DW] = zs;
            len = 6'(DW);
        end else if (addr[5:3] == A_DATA_HI && in_range) begin
            if (mode[MB_WIDE]) begin
                val[FW-1 -: DW] = data[idx];
                len = 6'(DW);
            end else begin
                val[FW-1 -: 16] = data[idx][DW-1 -: 16];
                len = 6'd16;
            end
        end else if (addr[5:3] == A_STAT_HI && in_range) begin
            val[FW-1 -: 8] = stat[idx];
        end else if (addr == A_MODE) begin
            val[FW-1 -: 8] = mode;
        end
    end
endmodule

// File: rtl/ser_reg_ctrl.sv
module ser_reg_ctrl
    import ser_reg_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int DW          = 24,
    parameter int SYNC_STAGES = 2,
    parameter int RST_ONES    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    sdi,
    input  logic                    stat_wr,
    input  logic [2:0]              stat_sel,
    input  logic [7:0]              stat_val,
    input  logic [NCH*DW-1:0]       conv_data,
    output logic                    sdo,
    output logic                    sdo_en,
    output logic [7:0]              mode_val,
    output logic [2:0]              mode_ch,
    output logic [DW-1:0]           zs_cal
);
    localparam int FW  = 8 + DW;
    localparam int OW  = $clog2(RST_ONES + 1);
    localparam logic [OW-1:0] ONES_MAX = OW'(RST_ONES);
    localparam logic [DW-1:0] ZS_RST = DW'(1) << (DW - 1);
    localparam logic [2:0]    PIN_RST = 3'b110;

    typedef struct packed {
        ser_st_e            st;
        logic [5:0]         cnt;
        logic [5:0]         len;
        logic [5:0]         addr;
        logic [DW-1:0]      ish;
        logic [FW-1:0]      osh;
        logic               ld;
        logic               sdo;
        logic               sdo_en;
        logic [OW-1:0]      ones;
        logic [7:0]         mode;
        logic [2:0]         mch;
        logic [DW-1:0]      zs;
        logic [NCH-1:0][7:0] stat;
        logic               sp;
    } ctl_t;

    function automatic ctl_t defaults();
        ctl_t s;
        s      = '0;
        s.st   = ST_CMD;
        s.len  = 6'd8;
        s.zs   = ZS_RST;
        s.sp   = 1'b1;
        for (int i = 0; i < NCH; i++) s.stat[i] = 8'(i * 32);
        return s;
    endfunction

    ctl_t q, n;

    // pin synchronisers: {cs_n, sclk, sdi}
    logic [2:0] pin_raw, pin_s;
    assign pin_raw = {cs_n, sclk, sdi};
    for (genvar i = 0; i < 3; i++) begin : g_pin
        ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[i])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .q(pin_s[i])
        );
    end

    logic cs_s, sclk_s, sdi_s, rise, fall;
    assign cs_s   = pin_s[2];
    assign sclk_s = pin_s[1];
    assign sdi_s  = pin_s[0];
    assign rise   = !cs_s && sclk_s && !q.sp;
    assign fall   = !cs_s && !sclk_s && q.sp;

    logic [NCH-1:0][DW-1:0] data_a;
    assign data_a = conv_data;

    logic [5:0]    rd_addr, rd_len, fr_len, frame_len;
    logic [FW-1:0] rd_val, fr_val, frame;
    logic [DW-1:0] ish_nx;
    logic [OW-1:0] ones_n;

    assign rd_addr = {q.ish[4:0], sdi_s};
    assign ish_nx  = {q.ish[DW-2:0], sdi_s};
    assign ones_n  = !sdi_s ? '0 : (q.ones == ONES_MAX) ? q.ones : q.ones + 1'b1;

    ser_rdmux #(.NCH(NCH), .DW(DW), .FW(FW)) u_rd (
        .addr(rd_addr), .mode(q.mode), .zs(q.zs), .stat(q.stat),
        .data(data_a), .val(rd_val), .len(rd_len)
    );

    ser_rdmux #(.NCH(NCH), .DW(DW), .FW(FW)) u_fr (
        .addr({A_DATA_HI, q.mch}), .mode(q.mode), .zs(q.zs), .stat(q.stat),
        .data(data_a), .val(fr_val), .len(fr_len)
    );

    assign frame     = {q.stat[q.mch], fr_val[FW-1:8]};
    assign frame_len = 6'd8 + fr_len;

    always_comb begin
        n    = q;
        n.sp = sclk_s;
        if (stat_wr) n.stat[stat_sel] = stat_val;

        if (cs_s) begin
            n.cnt  = '0;
            n.ones = '0;
            n.ld   = 1'b0;
            if (q.mode[MB_CONT]) begin
                n.st  = ST_STREAM;
                n.osh = frame;
                n.len = frame_len;
            end else begin
                n.st  = ST_CMD;
            end
        end else if (rise) begin
            if (ones_n == ONES_MAX) begin
                n      = defaults();
                n.sp   = sclk_s;
                n.ones = ones_n;
            end else begin
                n.ones = ones_n;
                n.ish  = ish_nx;
                n.cnt  = q.cnt + 6'd1;
                unique case (q.st)
                    ST_CMD: begin
                        if (q.cnt == 6'd7) begin
                            n.cnt = '0;
                            if (!q.ish[6]) begin
                                n.addr = rd_addr;
                                n.len  = rd_len;
                                if (q.ish[5]) begin
                                    n.st  = ST_RD;
                                    n.osh = rd_val;
                                end else begin
                                    n.st  = ST_WR;
                                end
                            end
                        end
                    end
                    ST_WR: begin
                        if (q.cnt == q.len - 6'd1) begin
                            n.cnt = '0;
                            n.st  = ST_CMD;
                            if (q.addr == A_ZSCAL) begin
                                n.zs = ish_nx;
                            end else if (q.addr[5:3] == A_MODE_HI) begin
                                n.mode = ish_nx[7:0];
                                n.mch  = q.addr[2:0];
                                if (ish_nx[MB_CONT]) begin
                                    n.st = ST_STREAM;
                                    n.ld = 1'b1;
                                end
                            end
                        end
                    end
                    ST_RD: begin
                        if (q.cnt == q.len - 6'd1) begin
                            n.cnt = '0;
                            n.st  = ST_CMD;
                        end
                    end
                    ST_STREAM: begin
                        if (q.cnt == 6'd0 && sdi_s) begin
                            n.mode[MB_CONT] = 1'b0;
                            n.st  = ST_CMD;
                            n.cnt = '0;
                        end else if (q.cnt == q.len - 6'd1) begin
                            n.cnt = '0;
                            n.ld  = 1'b1;
                        end
                    end
                    default: n.st = ST_CMD;
                endcase
            end
        end else if (fall) begin
            if (q.st == ST_RD || q.st == ST_STREAM) begin
                n.sdo = q.osh[FW-1];
                n.osh = q.osh << 1;
            end
        end else if (q.ld) begin
            n.ld  = 1'b0;
            n.osh = frame;
            n.len = frame_len;
        end

        n.sdo_en = !cs_s && (n.st == ST_RD || n.st == ST_STREAM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= defaults();
        else        q <= n;
    end

    assign sdo      = q.sdo;
    assign sdo_en   = q.sdo_en;
    assign mode_val = q.mode;
    assign mode_ch  = q.mch;
    assign zs_cal   = q.zs;

    p_wr_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR) |-> ($past(q.st) == ST_CMD || $past(q.st) == ST_WR));

    p_cnt_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_CMD) |-> (q.cnt < q.len));

    p_sdo_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(q.sdo));

    p_drive_only_reading_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> (q.st == ST_RD || q.st == ST_STREAM));

    p_pattern_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ones == ONES_MAX) |-> (q.zs == ZS_RST && q.mode == 8'h00 && q.st == ST_CMD));
endmodule

// File: tb/ser_reg_ctrl_test.sv
module ser_reg_ctrl_test;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic stat_wr = 1'b0;
    logic [2:0] stat_sel = '0;
    logic [7:0] stat_val = '0;
    logic [191:0] conv_data;
    logic sdo, sdo_en;
    logic [7:0] mode_val;
    logic [2:0] mode_ch;
    logic [23:0] zs_cal;

    int checks = 0, errs = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ser_reg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .stat_wr(stat_wr), .stat_sel(stat_sel), .stat_val(stat_val),
        .conv_data(conv_data), .sdo(sdo), .sdo_en(sdo_en),
        .mode_val(mode_val), .mode_ch(mode_ch), .zs_cal(zs_cal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit1(input logic b, output logic r);
        sdi  = b;
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        r    = sdo;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic send8(input logic [7:0] c);
        logic r;
        for (int i = 7; i >= 0; i--) bit1(c[i], r);
    endtask

    task automatic get_bits(input int nb, output logic [31:0] v);
        logic r;
        v = '0;
        for (int i = 0; i < nb; i++) begin
            bit1(1'b0, r);
            v = {v[30:0], r};
        end
    endtask

    task automatic put_bits(input int nb, input logic [31:0] v);
        logic r;
        for (int i = nb - 1; i >= 0; i--) bit1(v[i], r);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        sdi  = 1'b0;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] c, input int nb, output logic [31:0] v);
        cs_lo(); send8(c); get_bits(nb, v); cs_hi();
    endtask

    task automatic wr(input logic [7:0] c, input int nb, input logic [31:0] v);
        cs_lo(); send8(c); put_bits(nb, v); cs_hi();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 zs_cal", {8'h0, zs_cal}, 32'h800000);
        chk("R1 mode_val", {24'h0, mode_val}, 32'h0);
        chk("R1 mode_ch", {29'h0, mode_ch}, 32'h0);
        chk("R1 sdo_en", {31'h0, sdo_en}, 32'h0);
        rd(8'h65, 8, v);
        chk("R1 status5", v, 32'hA0);
    endtask

    task automatic t_zs();
        logic [31:0] v;
        wr(8'h06, 24, 32'h123456);
        chk("R3 zs_cal write", {8'h0, zs_cal}, 32'h123456);
        cs_lo(); send8(8'h46);
        chk("R4 sdo_en during read", {31'h0, sdo_en}, 32'h1);
        get_bits(24, v); cs_hi();
        chk("R4 read zs", v, 32'h123456);
    endtask

    task automatic t_badcmd();
        logic [31:0] v;
        cs_lo(); send8(8'h86); send8(8'h46); get_bits(24, v); cs_hi();
        chk("R2 discarded byte then read", v, 32'h123456);
        chk("R2 zs unchanged", {8'h0, zs_cal}, 32'h123456);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk); stat_sel = 3'd2; stat_val = 8'h5B; stat_wr = 1'b1;
        @(negedge clk); stat_wr = 1'b0;
        rd(8'h62, 8, v);
        chk("R5 status2 loaded", v, 32'h5B);
    endtask

    task automatic t_width();
        logic [31:0] v;
        rd(8'h4D, 16, v);
        chk("R6 16-bit data ch5", v, 32'hF0E1);
        wr(8'h38, 8, 32'h02);
        rd(8'h4D, 24, v);
        chk("R6 24-bit data ch5", v, 32'hF0E1D2);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'h3D, 8, 32'h81);
        chk("R7 mode_val", {24'h0, mode_val}, 32'h81);
        chk("R7 mode_ch", {29'h0, mode_ch}, 32'h5);
        rd(8'h78, 8, v);
        chk("R7 read base alias", v, 32'h81);
        rd(8'h7D, 8, v);
        chk("R7 read other alias", v, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(8'h20, 8, 32'hAA);
        rd(8'h60, 8, v);
        chk("R8 status write ignored", v, 32'h00);
        wr(8'h01, 8, 32'hFF);
        chk("R8 unmapped write", {8'h0, zs_cal}, 32'h123456);
        rd(8'h41, 8, v);
        chk("R8 unmapped read", v, 32'h0);
    endtask

    task automatic t_cs();
        logic [31:0] v;
        logic r;
        for (int i = 0; i < 40; i++) bit1(1'b1, r);
        chk("R9 sdo_en while deselected", {31'h0, sdo_en}, 32'h0);
        chk("R9 zs after ignored clocks", {8'h0, zs_cal}, 32'h123456);
        cs_lo(); bit1(1'b0, r); bit1(1'b1, r); bit1(1'b0, r); bit1(1'b0, r); cs_hi();
        rd(8'h46, 24, v);
        chk("R9 partial abandoned", v, 32'h123456);
    endtask

    task automatic t_stream();
        logic [31:0] v;
        logic r;
        cs_lo(); send8(8'h3B); put_bits(8, 32'h06);
        get_bits(32, v);
        chk("R11 first frame", v, 32'h603C5A96);
        get_bits(32, v);
        chk("R11 second frame", v, 32'h603C5A96);
        bit1(1'b1, r);
        send8(8'h78); get_bits(8, v); cs_hi();
        chk("R12 mode after exit", v, 32'h02);
        chk("R12 mode_val after exit", {24'h0, mode_val}, 32'h02);
    endtask

    task automatic t_pattern();
        logic [31:0] v;
        cs_lo(); send8(8'h38); put_bits(32, 32'hFFFFFFFF);
        send8(8'h46); get_bits(24, v); cs_hi();
        chk("R10 read after pattern", v, 32'h800000);
        chk("R10 zs_cal default", {8'h0, zs_cal}, 32'h800000);
        chk("R10 mode cleared", {24'h0, mode_val}, 32'h0);
        rd(8'h62, 8, v);
        chk("R10 status2 default", v, 32'h40);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) conv_data[24*i +: 24] = 24'h111111 * i;
        conv_data[24*3 +: 24] = 24'h3C5A96;
        conv_data[24*5 +: 24] = 24'hF0E1D2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_zs();
        t_badcmd();
        t_status();
        t_width();
        t_alias();
        t_ignored();
        t_cs();
        t_stream();
        t_pattern();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule